// File: doc/BRIEF.md
# Stereo Digital Volume Attenuator with Staged Update

This block scales a stereo stream of signed 24-bit samples by a per-channel volume code. Each code is 8 bits wide, and each step is half a decibel. The left and right channels each hold two copies of their code. One is a holding latch that a register write fills. The other is the live code that actually scales the samples. A write can park a new code in a holding latch. A write carrying the apply flag moves every holding latch into its live code together, so a balance change lands on both channels in the same sample.

A single write to the shared address fills both holding latches at once. A live code changes only when a sample is accepted. The sample accepted first after an applying write is scaled by the new codes. A zero detector counts consecutive zero samples on each channel. The pair's zero flag rises once both channels have seen a long enough run of zeros, and it is also raised when the pair is muted or powered down.

Top module: `stereo_atten`

## Requirements
- R1: After reset, both holding latches and both live codes equal 8'hFF (unity gain), `out_valid` is 0, `out_l` and `out_r` are 0, and `zero_flag` is 0.
- R2: The output is floor((x*c + 2^14) / 2^15), clamped to the 24-bit signed range, for sample x and coefficient c. The coefficient c is computed from the live code g as follows. Code g = 0 gives c = 0 (mute). Otherwise let d = 255 - g; then c = round(32768 * 10^(-(d mod 12)/40)) shifted right by floor(d/12).
- R3: A write with `wr_upd` = 0 changes only the addressed holding latch. Samples keep being scaled by the previous live codes.
- R4: A write with `wr_upd` = 1 stores its data and marks an update. At the next accepted sample, both live codes take the values of their holding latches, and that sample is already scaled by them.
- R5: Address encoding: 0 selects the left latch, 1 the right latch, and 2 both latches together. A write to address 3 changes nothing, even when `wr_upd` = 1.
- R6: A channel's zero detector is set once 1024 consecutive zero samples have been accepted on it. `zero_flag` needs both channels set; one channel alone leaves it low.
- R7: An accepted nonzero sample on a channel clears that channel's zero run at once.
- R8: While `mute` or `pdn` is high, `zero_flag` is high and every accepted sample produces 0 on both outputs.
- R9: Each accepted sample (`in_valid` high at a clock edge) yields exactly one `out_valid` pulse, one cycle later. The outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 left, 1 right, 2 both, 3 none |
| wr_data | input | 8 | Volume code (FF = 0 dB, 00 = mute) |
| wr_upd | input | 1 | Apply flag: move all holding latches to live codes |
| mute | input | 1 | Pair mute request |
| pdn | input | 1 | Pair power-down indication |
| in_valid | input | 1 | Sample pair strobe |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair strobe |
| out_l | output | 24 | Left scaled sample, signed |
| out_r | output | 24 | Right scaled sample, signed |
| zero_flag | output | 1 | Pair zero / muted indication |

## Verification
The bench parks a code without applying it. A design that loaded live codes on every write would change the output too early. It writes to the unused address with the apply flag set. An over-eager decoder would either fire an update or corrupt a latch. It probes the zero-run threshold at 1023 and 1024 samples, with a run on one channel only, and with a single nonzero sample after the flag has risen. An off-by-one counter, an OR in place of an AND across channels, or a sticky flag would each show up there. Negative samples at exact half-LSB products check the rounding direction. Mute code 0 and the minimum code 1 check that the quietest settings really give silence.

// File: rtl/stereo_atten.sv
module stereo_atten #(
  parameter int DW     = 24,
  parameter int ZCOUNT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 wr_upd,
  input  logic                 mute,
  input  logic                 pdn,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 zero_flag
);
  localparam int CW = 16;
  localparam int SH = CW - 1;
  localparam int PW = DW + CW + 1;
  localparam int ZW = $clog2(ZCOUNT + 1);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(64'sd1 <<< (DW - 1)));

  function automatic logic [CW-1:0] coef_of(input logic [7:0] code);
    logic [7:0] d;
    logic [CW-1:0] b;
    d = 8'd255 - code;
    case (d % 8'd12)
      8'd0:    b = 16'd32768;
      8'd1:    b = 16'd30935;
      8'd2:    b = 16'd29205;
      8'd3:    b = 16'd27571;
      8'd4:    b = 16'd26029;
      8'd5:    b = 16'd24573;
      8'd6:    b = 16'd23198;
      8'd7:    b = 16'd21900;
      8'd8:    b = 16'd20675;
      8'd9:    b = 16'd19519;
      8'd10:   b = 16'd18427;
      default: b = 16'd17396;
    endcase
    coef_of = (code == 8'd0) ? '0 : (b >> (d / 8'd12));
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [CW-1:0] c);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] q;
    p = PW'(x) * $signed({1'b0, c});
    q = (p + RND) >>> SH;
    if (q > MAXV)      q = MAXV;
    else if (q < MINV) q = MINV;
    scale = q[DW-1:0];
  endfunction

  logic [7:0]    lat [2];
  logic [7:0]    act [2];
  logic [7:0]    eff [2];
  logic [ZW-1:0] zcnt [2];
  logic signed [DW-1:0] xin [2];
  logic pend, apply, silent;

  assign xin[0] = in_l;
  assign xin[1] = in_r;
  assign apply  = pend & in_valid;
  assign silent = mute | pdn;
  assign eff[0] = apply ? lat[0] : act[0];
  assign eff[1] = apply ? lat[1] : act[1];
  assign zero_flag = ((zcnt[0] == ZW'(ZCOUNT)) && (zcnt[1] == ZW'(ZCOUNT))) || silent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      for (int i = 0; i < 2; i++) begin
        lat[i]  <= 8'hFF;
        act[i]  <= 8'hFF;
        zcnt[i] <= '0;
      end
    end else begin
      if (apply) begin
        act[0] <= lat[0];
        act[1] <= lat[1];
      end
      if (wr_en && wr_addr != 2'd3) begin
        if (wr_addr != 2'd1) lat[0] <= wr_data;
        if (wr_addr != 2'd0) lat[1] <= wr_data;
      end
      if (wr_en && wr_addr != 2'd3 && wr_upd) pend <= 1'b1;
      else if (in_valid)                      pend <= 1'b0;
      out_valid <= in_valid;
      if (in_valid) begin
        out_l <= silent ? '0 : scale(in_l, coef_of(eff[0]));
        out_r <= silent ? '0 : scale(in_r, coef_of(eff[1]));
        for (int i = 0; i < 2; i++)
          if (xin[i] != '0)                  zcnt[i] <= '0;
          else if (zcnt[i] != ZW'(ZCOUNT))   zcnt[i] <= zcnt[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stereo_atten_chk.sv
module stereo_atten_chk #(
  parameter int DW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mute,
  input logic                 pdn,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_l,
  input logic signed [DW-1:0] in_r,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 zero_flag
);
  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    logic signed [DW:0] w;
    w = DW'(v);
    w = {v[DW-1], v};
    mag = (w < 0) ? -w : w;
  endfunction

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_l) && $stable(out_r))); // R9
  AST_SILENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mute || pdn)) |=> (out_l == '0 && out_r == '0)); // R8
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_l == '0 && in_r == '0) |=> (out_l == '0 && out_r == '0)); // R2
  AST_NEVER_LOUDER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mag(out_l) <= mag($past(in_l)) && mag(out_r) <= mag($past(in_r)))); // R2
  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_l != '0 || in_r != '0)) |=> (!zero_flag || mute || pdn)); // R7
endmodule

bind stereo_atten stereo_atten_chk #(.DW(DW)) i_stereo_atten_chk (
  .clk(clk), .rst_n(rst_n), .mute(mute), .pdn(pdn), .in_valid(in_valid),
  .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_l(out_l),
  .out_r(out_r), .zero_flag(zero_flag));

// File: tb/test_stereo_atten.sv
module test_stereo_atten;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_upd = 1'b0, mute = 1'b0, pdn = 1'b0, in_valid = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic out_valid, zero_flag;
  logic signed [DW-1:0] out_l, out_r;

  int n_checks = 0, n_fail = 0;
  int m_lat [2] = '{255, 255};
  int m_act [2] = '{255, 255};
  bit m_pend = 1'b0;
  longint q_l [$];
  longint q_r [$];
  string  q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_atten i_stereo_atten (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_upd(wr_upd), .mute(mute), .pdn(pdn), .in_valid(in_valid), .in_l(in_l),
    .in_r(in_r), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .zero_flag(zero_flag));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint bcoef(input int code);
    int d;
    longint base;
    if (code == 0) return 0;
    d = 255 - code;
    base = longint'($rtoi(32768.0 * (10.0 ** (-(d % 12) / 40.0)) + 0.5));
    return base >>> (d / 12);
  endfunction

  function automatic longint expect_of(input longint x, input int code);
    longint q;
    q = (x * bcoef(code) + 16384) >>> 15;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic write(input int addr, input int data, input bit upd);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data); wr_upd = upd;
    @(negedge clk);
    wr_en = 1'b0; wr_upd = 1'b0;
    if (addr != 3) begin
      if (addr != 1) m_lat[0] = data;
      if (addr != 0) m_lat[1] = data;
      if (upd) m_pend = 1'b1;
    end
  endtask

  task automatic send(input longint l, input longint r, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_l = DW'(l); in_r = DW'(r);
    if (m_pend) begin
      m_act = m_lat;
      m_pend = 1'b0;
    end
    q_l.push_back((mute || pdn) ? 0 : expect_of(l, m_act[0]));
    q_r.push_back((mute || pdn) ? 0 : expect_of(r, m_act[1]));
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", 1, 0);
      end else begin
        longint el, er;
        string t;
        el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
        check(longint'(out_l) == el, {t, " left"}, longint'(out_l), el);
        check(longint'(out_r) == er, {t, " right"}, longint'(out_r), er);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(out_l == '0 && out_r == '0, "R1 outputs after reset", out_l, 0);
    check(zero_flag == 1'b0, "R1 zero_flag after reset", zero_flag, 0);
    send(1000, -1000, "R1 unity default");
    send(8388607, -8388608, "R1 unity full scale");

    write(0, 8'hF3, 1'b0);
    send(123457, -654321, "R3 parked code keeps old gain");
    write(1, 8'h80, 1'b1);
    send(123457, -77777, "R4 applied codes");
    send(-4000000, 4000001, "R4 codes persist");

    write(2, 8'hE0, 1'b0);
    send(555555, 555555, "R5 master parked only");
    write(3, 8'h10, 1'b1);
    send(555555, -555555, "R5 address 3 ignored");
    write(0, 8'hFE, 1'b1);
    send(777777, 777777, "R5 master reached right latch");

    write(2, 8'h00, 1'b1);
    send(8388607, -8388608, "R2 code 00 mutes");
    write(2, 8'h01, 1'b1);
    send(8388607, -8388608, "R2 code 01 near silence");
    write(2, 8'd243, 1'b1);
    send(-5, 5, "R2 rounding half step");
    send(-3, 3, "R2 rounding negative");
    for (int k = 0; k < 24; k++) begin
      write(2, 255 - k * 11, 1'b1);
      send(7654321 - k * 1000, -(3000000 + k * 77), "R2 code sweep");
    end
    write(2, 8'hFF, 1'b1);

    for (int k = 0; k < 1023; k++) send(0, 0, "R6 zero run");
    @(negedge clk);
    check(zero_flag == 1'b0, "R6 flag low at 1023 zeros", zero_flag, 0);
    send(0, 0, "R6 zero run");
    @(negedge clk);
    check(zero_flag == 1'b1, "R6 flag high at 1024 zeros", zero_flag, 1);
    send(5, 0, "R7 nonzero sample");
    @(negedge clk);
    check(zero_flag == 1'b0, "R7 nonzero clears flag", zero_flag, 0);
    for (int k = 0; k < 1100; k++) send(0, 7, "R6 one channel only");
    @(negedge clk);
    check(zero_flag == 1'b0, "R6 one channel leaves flag low", zero_flag, 0);

    @(negedge clk) mute = 1'b1;
    @(negedge clk);
    check(zero_flag == 1'b1, "R8 mute raises flag", zero_flag, 1);
    send(4444, -4444, "R8 muted output");
    @(negedge clk) begin mute = 1'b0; pdn = 1'b1; end
    @(negedge clk);
    check(zero_flag == 1'b1, "R8 pdn raises flag", zero_flag, 1);
    send(-9999, 9999, "R8 powered down output");
    @(negedge clk) pdn = 1'b0;
    send(31, -31, "R9 normal after release");
    repeat (4) @(negedge clk);
    check(q_tag.size() == 0, "R9 every sample produced output", q_tag.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule